// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog peripheral on a simple 32-bit register bus. A 16-bit down-counter takes one step on each tick of a two-stage clock divider. The first stage is an 8-bit programmable prescaler that divides the clock by P+1. The second stage is a fixed divide of 16, 32, 64 or 128, chosen by a 2-bit field. The counter reaches the end of its count N after N ticks. At that point it reloads from a reload register and keeps running, so the same block works as a periodic interval timer. Each expiry can raise a level interrupt, start a fixed-length system reset pulse, or do both. Each of these actions has its own enable bit.

Software keeps the watchdog alive by writing the count register. The write loads the live counter at once. A pending interrupt stays asserted until software writes 1 to a dedicated clear register.

The block holds three small state machines:

- **Counter** (`RUN_HALT`, `RUN_ACTIVE`). `HALT→ACTIVE` when the enable bit is set. `ACTIVE→HALT` when the enable bit is cleared.
- **Interrupt** (`IRQ_IDLE`, `IRQ_PEND`). `IDLE→PEND` on an expiry with the interrupt enabled. `PEND→IDLE` on a clear write, unless a new expiry arrives in the same cycle.
- **Reset pulse** (`PULSE_IDLE`, `PULSE_DRIVE`). `IDLE→DRIVE` on an expiry with reset enabled. `DRIVE→IDLE` when the pulse-length counter runs out.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset the control register reads 0x0000_8019 (reset action on, divide-by-128 selected, prescaler 0x80, counting off). The count and reload registers read 0x8000. `irq` and `wdt_rst` are low.
- R2: The register offsets are: control 0x0, reload 0x4, live count 0x8, interrupt clear 0xC. Control stores only bits 0, 2, 3, 4, 5 and 15:8, and all other bits read zero. Reload and count are 16 bits wide. The clear register reads zero.
- R3: Control bit 5 enables counting, and bits 15:8 hold the prescaler value P. Bits 4:3 select the post-divide: 00 divides by 16, 01 by 32, 10 by 64 and 11 by 128. While counting is enabled, the counter steps once every (P+1)·D clocks, where D is the post-divide. The first step comes (P+1)·D clocks after the enabling write.
- R4: An expiry occurs on the tick that finds the count at 1 or 0. On that tick the counter reloads from the reload register and keeps counting. A count of N therefore expires N·(P+1)·D clocks after enable, and then again every N·(P+1)·D clocks.
- R5: A write of any value to the count register (bits 15:0) loads the live counter on the next clock. Regular writes prevent expiry.
- R6: Clearing control bit 5 stops the counter, and the counter then holds its value.
- R7: With control bit 2 set, an expiry sets `irq` on the expiry edge. `irq` then stays high until a write to the clear register with bit 0 = 1. A write with bit 0 = 0 leaves `irq` unchanged.
- R8: With control bit 0 set, an expiry drives `wdt_rst` high for exactly RST_CYCLES (8) clocks, starting on the expiry edge. With bit 0 clear, an expiry leaves `wdt_rst` low.
- R9: Use this setup: count 0x80, prescaler 0x20, divide-by-16, reset enabled. Then `wdt_rst` rises exactly 0x80·33·16 = 67584 clocks after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Expiry interrupt, level |
| wdt_rst | output | 1 | System reset pulse |

## Verification
A wrong divider phase or terminal count moves the `irq` or `wdt_rst` edge by at least one clock. The bench measures every expiry to the exact cycle, so that error shows on the first expiry. A fault in the counter's hold or reload path appears on the next register read, or one period later as a missing or early second expiry. A fault in the interrupt or pulse state machines appears within a few clocks of an expiry or a clear write, as a level or pulse length that differs from the computed one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BUS_AW = 4;
    localparam int BUS_DW = 32;
    localparam int PRE_W  = 8;
    localparam int SEL_W  = 2;

    localparam logic [BUS_AW-1:0] OFF_CTRL   = 4'h0;
    localparam logic [BUS_AW-1:0] OFF_RELOAD = 4'h4;
    localparam logic [BUS_AW-1:0] OFF_COUNT  = 4'h8;
    localparam logic [BUS_AW-1:0] OFF_CLEAR  = 4'hC;

    localparam int BIT_RST_EN = 0;
    localparam int BIT_IRQ_EN = 2;
    localparam int BIT_SEL_LO = 3;
    localparam int BIT_RUN    = 5;
    localparam int BIT_PRE_LO = 8;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             run;
        logic [SEL_W-1:0] sel;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    typedef enum logic {RUN_HALT, RUN_ACTIVE} run_state_e;
    typedef enum logic {IRQ_IDLE, IRQ_PEND} irq_state_e;
    typedef enum logic {PULSE_IDLE, PULSE_DRIVE} pulse_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  live_count,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wr_val,
    output logic              irq_clr,
    output logic [BUS_DW-1:0] bus_rdata
);

    logic wr;
    logic [BUS_DW-1:0] ctrl_word;

    assign wr         = bus_valid && bus_write;
    assign cnt_wr     = wr && (bus_addr == OFF_COUNT);
    assign cnt_wr_val = bus_wdata[CNT_W-1:0];
    assign irq_clr    = wr && (bus_addr == OFF_CLEAR) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl.pre    <= 8'h80;
            ctrl.run    <= 1'b0;
            ctrl.sel    <= 2'b11;
            ctrl.irq_en <= 1'b0;
            ctrl.rst_en <= 1'b1;
            reload_val  <= CNT_RST;
        end else if (wr) begin
            if (bus_addr == OFF_CTRL) begin
                ctrl.pre    <= bus_wdata[BIT_PRE_LO +: PRE_W];
                ctrl.run    <= bus_wdata[BIT_RUN];
                ctrl.sel    <= bus_wdata[BIT_SEL_LO +: SEL_W];
                ctrl.irq_en <= bus_wdata[BIT_IRQ_EN];
                ctrl.rst_en <= bus_wdata[BIT_RST_EN];
            end
            if (bus_addr == OFF_RELOAD) begin
                reload_val <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[BIT_PRE_LO +: PRE_W] = ctrl.pre;
        ctrl_word[BIT_RUN]             = ctrl.run;
        ctrl_word[BIT_SEL_LO +: SEL_W] = ctrl.sel;
        ctrl_word[BIT_IRQ_EN]          = ctrl.irq_en;
        ctrl_word[BIT_RST_EN]          = ctrl.rst_en;
    end

    always_comb begin
        case (bus_addr)
            OFF_CTRL:   bus_rdata = ctrl_word;
            OFF_RELOAD: bus_rdata = BUS_DW'(reload_val);
            OFF_COUNT:  bus_rdata = BUS_DW'(live_count);
            default:    bus_rdata = '0;
        endcase
    end

    // Stored control fields follow a control write
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFF_CTRL) |=> (ctrl.run == $past(bus_wdata[BIT_RUN])));

endmodule

// File: rtl/wdog_divider.sv
module wdog_divider
    import wdog_pkg::*;
#(
    parameter int POST_BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_val,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int N_SEL    = 1 << SEL_W;
    localparam int POST_W   = POST_BASE_LOG2 + N_SEL - 1;

    logic [PRE_W-1:0]  pre_cnt;
    logic [POST_W-1:0] post_cnt;
    logic [POST_W-1:0] post_top_tab [N_SEL];
    logic [POST_W-1:0] post_top;
    logic              pre_last;
    logic              post_last;

    for (genvar g = 0; g < N_SEL; g++) begin : g_post_top
        assign post_top_tab[g] = POST_W'((1 << (POST_BASE_LOG2 + g)) - 1);
    end

    assign post_top  = post_top_tab[sel];
    assign pre_last  = (pre_cnt >= pre_val);
    assign post_last = (post_cnt >= post_top);
    assign tick      = run && pre_last && post_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (!run) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt  <= '0;
            post_cnt <= post_last ? '0 : post_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

    // Ticks are at least 16 clocks apart
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // A stopped divider stays at phase zero
    p_idle_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0 && post_cnt == '0));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] CNT_RST = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wr_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    run_state_e state, state_nx;
    logic       at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RUN_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RUN_HALT:   if (run)  state_nx = RUN_ACTIVE;
            RUN_ACTIVE: if (!run) state_nx = RUN_HALT;
        endcase
    end

    assign at_end = (count <= CNT_W'(1));
    assign expire = (state == RUN_ACTIVE) && tick && !cnt_wr && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CNT_RST;
        end else if (cnt_wr) begin
            count <= cnt_wr_val;
        end else if (state == RUN_ACTIVE && tick) begin
            count <= at_end ? reload_val : count - 1'b1;
        end
    end

    p_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(cnt_wr_val)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(reload_val)));

endmodule

// File: rtl/wdog_out.sv
module wdog_out
    import wdog_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_en,
    input  logic rst_en,
    input  logic irq_clr,
    output logic irq,
    output logic wdt_rst
);

    localparam int PC_W = $clog2(RST_CYCLES + 1);
    localparam int HL_W = $clog2(RST_CYCLES + 2);

    irq_state_e   irq_st, irq_nx;
    pulse_state_e pls_st, pls_nx;
    logic [PC_W-1:0] pls_cnt;
    logic set_irq;
    logic start_pls;

    assign set_irq   = expire && irq_en;
    assign start_pls = expire && rst_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_st <= IRQ_IDLE;
            pls_st <= PULSE_IDLE;
        end else begin
            irq_st <= irq_nx;
            pls_st <= pls_nx;
        end
    end

    always_comb begin
        irq_nx = irq_st;
        unique case (irq_st)
            IRQ_IDLE: if (set_irq)              irq_nx = IRQ_PEND;
            IRQ_PEND: if (irq_clr && !set_irq)  irq_nx = IRQ_IDLE;
        endcase
    end

    always_comb begin
        pls_nx = pls_st;
        unique case (pls_st)
            PULSE_IDLE:  if (start_pls)        pls_nx = PULSE_DRIVE;
            PULSE_DRIVE: if (pls_cnt == '0)    pls_nx = PULSE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pls_cnt <= '0;
        end else if (pls_st == PULSE_IDLE) begin
            if (start_pls) pls_cnt <= PC_W'(RST_CYCLES - 1);
        end else if (pls_cnt != '0) begin
            pls_cnt <= pls_cnt - 1'b1;
        end
    end

    always_comb begin
        irq     = (irq_st == IRQ_PEND);
        wdt_rst = (pls_st == PULSE_DRIVE);
    end

    // Checker state: length of the current reset pulse
    logic [HL_W-1:0] hi_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hi_len <= '0;
        else if (!wdt_rst)                       hi_len <= '0;
        else if (hi_len != HL_W'(RST_CYCLES + 1)) hi_len <= hi_len + 1'b1;
    end

    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_irq |=> irq);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !set_irq) |=> !irq);

    p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> $past(start_pls));

    p_rst_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst) |-> (hi_len == HL_W'(RST_CYCLES)));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int POST_BASE_LOG2 = 4,
    parameter int RST_CYCLES     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_rst
);

    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1) << (CNT_W - 1);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cnt_wr_val;
    logic             cnt_wr;
    logic             irq_clr;
    logic             tick;
    logic             expire;

    wdog_regs #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .live_count (count),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .cnt_wr     (cnt_wr),
        .cnt_wr_val (cnt_wr_val),
        .irq_clr    (irq_clr),
        .bus_rdata  (bus_rdata)
    );

    wdog_divider #(.POST_BASE_LOG2(POST_BASE_LOG2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .pre_val (ctrl.pre),
        .sel     (ctrl.sel),
        .tick    (tick)
    );

    wdog_counter #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl.run),
        .tick       (tick),
        .cnt_wr     (cnt_wr),
        .cnt_wr_val (cnt_wr_val),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire)
    );

    wdog_out #(.RST_CYCLES(RST_CYCLES)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .irq_en  (ctrl.irq_en),
        .rst_en  (ctrl.rst_en),
        .irq_clr (irq_clr),
        .irq     (irq),
        .wdt_rst (wdt_rst)
    );

    // No expiry while counting is switched off
    p_no_expire_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !expire);

endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wdt_rst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdog_top i_wdog_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wdt_rst   (wdt_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; write lands on the following rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl(input int p, input int sel, input bit run,
                                        input bit ie, input bit re);
        return {16'h0, 8'(p), 2'b00, run, 2'(sel), ie, 1'b0, re};
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, d); check("R1 ctrl", d, 32'h0000_8019);
        rd(4'h4, d); check("R1 reload", d, 32'h8000);
        rd(4'h8, d); check("R1 count", d, 32'h8000);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 wdt_rst", {31'h0, wdt_rst}, 32'h0);

        // R2 map and reserved bits
        wr(4'h0, 32'hFFFF_FFDF);
        rd(4'h0, d); check("R2 ctrl mask", d, 32'h0000_FF1D);
        wr(4'h0, 32'h0);
        rd(4'h0, d); check("R2 ctrl zero", d, 32'h0);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d); check("R2 clear reads zero", d, 32'h0);
        wr(4'h4, 32'hABCD_5678);
        rd(4'h4, d); check("R2 reload width", d, 32'h5678);
        // R5 count write loads counter
        wr(4'h8, 32'h0000_1234);
        rd(4'h8, d); check("R5 count write", d, 32'h1234);

        // R3/R4/R7/R8 sweep: prescaler, post-divide, terminal count
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int n = 1; n <= 3; n++) begin
                    int len;
                    int c;
                    len = n * (p + 1) * (16 << s);
                    wr(4'h4, 32'(n));
                    wr(4'h8, 32'(n));
                    wr(4'h0, ctl(p, s, 1'b1, 1'b1, 1'b0));
                    c = 0;
                    while (!irq && c < len + 50) begin
                        @(negedge clk);
                        c++;
                    end
                    check($sformatf("R3 R4 first expiry p=%0d s=%0d n=%0d", p, s, n), c, len);
                    check("R8 no reset when disabled", {31'h0, wdt_rst}, 32'h0);
                    wr(4'hC, 32'h0);
                    check("R7 clear with bit0=0 ignored", {31'h0, irq}, 32'h1);
                    wr(4'hC, 32'h1);
                    check("R7 clear", {31'h0, irq}, 32'h0);
                    c = 0;
                    while (!irq && c < len + 50) begin
                        @(negedge clk);
                        c++;
                    end
                    check($sformatf("R4 reload period p=%0d s=%0d n=%0d", p, s, n), c, len - 4);
                    wr(4'h0, 32'h0);
                    wr(4'hC, 32'h1);
                end
            end
        end

        // R6 hold on disable
        wr(4'h8, 32'd100);
        wr(4'h0, ctl(0, 0, 1'b1, 1'b0, 1'b0));
        repeat (82) @(negedge clk);
        wr(4'h0, ctl(0, 0, 1'b0, 1'b0, 1'b0));
        rd(4'h8, d); check("R6 count after stop", d, 32'd95);
        repeat (40) @(negedge clk);
        rd(4'h8, d); check("R6 count held", d, 32'd95);

        // R5 refresh keeps the interrupt away
        wr(4'h4, 32'd4);
        wr(4'h8, 32'd4);
        wr(4'h0, ctl(0, 0, 1'b1, 1'b1, 1'b0));
        for (int k = 0; k < 6; k++) begin
            repeat (30) @(negedge clk);
            wr(4'h8, 32'd4);
            check("R5 refresh prevents expiry", {31'h0, irq}, 32'h0);
        end
        repeat (80) @(negedge clk);
        check("R5 expiry after refresh stops", {31'h0, irq}, 32'h1);
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h1);

        // R9 exact reset latency, R8 pulse length
        wr(4'h4, 32'h80);
        wr(4'h8, 32'h80);
        wr(4'h0, ctl(8'h20, 0, 1'b1, 1'b0, 1'b1));
        repeat (67584 - 1) @(negedge clk);
        check("R9 no reset one clock early", {31'h0, wdt_rst}, 32'h0);
        @(negedge clk);
        check("R9 reset at exact latency", {31'h0, wdt_rst}, 32'h1);
        check("R7 irq stays off when disabled", {31'h0, irq}, 32'h0);
        repeat (7) @(negedge clk);
        check("R8 pulse last cycle", {31'h0, wdt_rst}, 32'h1);
        @(negedge clk);
        check("R8 pulse ends after 8", {31'h0, wdt_rst}, 32'h0);
        wr(4'h0, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule